// File: doc/BRIEF.md
# Polynomial Sequence Self-Test Checker

This block judges a buffer of 64-bit words that a random source captured while it ran in a fixed, deterministic test mode. In that mode the source emits successive states of a shift-register sequence, so a healthy buffer holds a run of consecutive states that starts at an unknown offset. The checker starts from a seed value. On each pass it reads the buffer through a synchronous read port, skips slot 0 and counts how many of the other words equal the current expected state. Between passes it advances the expected state by one step of the sequence.

The match count is carried over from pass to pass. The run passes once that running total reaches a goal. It fails when the permitted number of passes is used up without reaching the goal. A start pulse launches a run. When the run ends, a one-cycle done pulse appears together with a pass flag, and the flag holds its value until the next run is accepted. Filling the buffer is outside this block.

The controller is a four-state machine:
- IDLE waits for start. An accepted start loads the seed and clears the total.
- READ issues one buffer read per cycle, for addresses 1 to DEPTH-1.
- DRAIN compares the last word, which returns one cycle after its read.
- JUDGE decides the outcome. It goes to IDLE when the goal has been met or the last pass is done. Otherwise it advances the expected state and goes back to READ.

Top module: `lfsr_selftest`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `pass` and `rd_en` are 0 until a start is accepted.
- R2: One sequence step maps value v to {v[62:0],0}. When v[63] was 1, the result is also XORed with the parameter POLY.
- R3: Each pass raises `rd_en` for DEPTH-1 consecutive cycles. In those cycles `rd_addr` takes the values 1, 2, …, DEPTH-1 in ascending order, and address 0 is never read. `rd_data` is taken as the word for the address presented one cycle earlier.
- R4: Matches found in every pass are added into one total. At the end of any pass where the total is at least GOAL, the run ends with pass = 1.
- R5: After each pass that ends with the total below GOAL, the expected value moves forward by exactly one step (R2) before the next pass.
- R6: If MAX_PASSES passes complete and the total is still below GOAL, the run ends with pass = 0.
- R7: `seed_sel` = 0 selects SEED_A as the first expected value, and `seed_sel` = 1 selects SEED_B. It is sampled with the accepted start.
- R8: `done` is high for exactly one cycle. It rises (DEPTH+1)·k clock edges after the edge that accepted start, where k is the number of passes the run used.
- R9: `pass` keeps its value from one done pulse until the edge after the next accepted start, where it clears to 0. It changes at no other time.
- R10: A start pulse that arrives while a run is in progress has no effect on that run's outcome or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run (accepted only when idle) |
| seed_sel | input | 1 | Seed choice: 0 = SEED_A, 1 = SEED_B |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | $clog2(DEPTH) | Buffer word address |
| rd_data | input | 64 | Buffer word, valid one cycle after the request |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last run, held |

## Verification
The assertions check the following on every cycle: `done` never lasts two cycles, reads never touch address 0 and rise one address at a time, no read is active while `done` is high, and `pass` moves only at a done pulse or just after a start. Only the bench scenarios can show the rest. These are the arithmetic of the sequence step, the carry of the total across passes, the goal being reached exactly on the last allowed pass versus one pass too late, the effect of the seed choice, and the exact done latency with and without a stray start during a run.

// File: rtl/lfsr_selftest_pkg.sv
package lfsr_selftest_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_DRAIN = 2'd2,
        S_JUDGE = 2'd3
    } chk_state_t;

    // one shift of the sequence: left shift, fold in the taps on carry-out
    function automatic logic [63:0] seq_step(input logic [63:0] v, input logic [63:0] taps);
        logic [63:0] r;
        r = {v[62:0], 1'b0};
        if (v[63]) r = r ^ taps;
        return r;
    endfunction

endpackage

// File: rtl/lfsr_selftest_seq.sv
module lfsr_selftest_seq
    import lfsr_selftest_pkg::*;
#(
    parameter logic [63:0] POLY   = 64'h231DCEE91262B8A3,
    parameter logic [63:0] SEED_A = 64'hC3A55A3C0F1E2D4B,
    parameter logic [63:0] SEED_B = 64'h8000000000000001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld,
    input  logic        adv,
    input  logic        seed_sel,
    output logic [63:0] expect_val
);
    logic [63:0] cur_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (ld) begin
            cur_q <= seed_sel ? SEED_B : SEED_A;
        end else if (adv) begin
            cur_q <= seq_step(cur_q, POLY);
        end
    end

    assign expect_val = cur_q;
endmodule

// File: rtl/lfsr_selftest_tally.sv
module lfsr_selftest_tally #(
    parameter int DEPTH = 8,
    parameter int GOAL  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        cmp_en,
    input  logic [63:0] word,
    input  logic [63:0] expect_val,
    output logic        goal_met
);
    localparam int CW = $clog2(GOAL + DEPTH + 1);

    logic [CW-1:0] total_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            total_q <= '0;
        end else if (cmp_en && (word == expect_val)) begin
            total_q <= total_q + 1'b1;
        end
    end

    assign goal_met = (total_q >= CW'(GOAL));
endmodule

// File: rtl/lfsr_selftest_ctrl.sv
module lfsr_selftest_ctrl
    import lfsr_selftest_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int MAX_PASSES = 16,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          goal_met,
    output logic          ld,
    output logic          adv,
    output logic          cmp_en,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          done,
    output logic          pass
);
    localparam int PW = $clog2(MAX_PASSES + 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    chk_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [PW-1:0] pcnt_q;
    logic          cmp_q, done_q, pass_q;
    logic          finish;

    assign finish = goal_met || (pcnt_q == PW'(MAX_PASSES - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_READ;
            S_READ:  if (addr_q == LAST_ADDR) state_d = S_DRAIN;
            S_DRAIN: state_d = S_JUDGE;
            S_JUDGE: state_d = finish ? S_IDLE : S_READ;
            default: state_d = S_IDLE;
        endcase
    end

    // control strobes
    assign ld      = (state_q == S_IDLE) && start;
    assign adv     = (state_q == S_JUDGE) && !finish;
    assign rd_en   = (state_q == S_READ);
    assign rd_addr = addr_q;
    assign cmp_en  = cmp_q;

    // outputs and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= AW'(1);
            pcnt_q <= '0;
            cmp_q  <= 1'b0;
            done_q <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            cmp_q  <= rd_en;
            done_q <= (state_q == S_JUDGE) && finish;
            if (ld || adv)           addr_q <= AW'(1);
            else if (rd_en)          addr_q <= addr_q + 1'b1;
            if (ld)                  pcnt_q <= '0;
            else if (adv)            pcnt_q <= pcnt_q + 1'b1;
            if (ld)                  pass_q <= 1'b0;
            else if ((state_q == S_JUDGE) && finish) pass_q <= goal_met;
        end
    end

    assign done = done_q;
    assign pass = pass_q;
endmodule

// File: rtl/lfsr_selftest.sv
module lfsr_selftest #(
    parameter int          DEPTH      = 8,
    parameter int          GOAL       = 3,
    parameter int          MAX_PASSES = 16,
    parameter logic [63:0] POLY       = 64'h231DCEE91262B8A3,
    parameter logic [63:0] SEED_A     = 64'hC3A55A3C0F1E2D4B,
    parameter logic [63:0] SEED_B     = 64'h8000000000000001,
    localparam int         AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          seed_sel,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [63:0]   rd_data,
    output logic          done,
    output logic          pass
);
    logic        ld, adv, cmp_en, goal_met;
    logic [63:0] expect_val;

    lfsr_selftest_ctrl #(.DEPTH(DEPTH), .MAX_PASSES(MAX_PASSES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .goal_met(goal_met),
        .ld(ld), .adv(adv), .cmp_en(cmp_en), .rd_en(rd_en),
        .rd_addr(rd_addr), .done(done), .pass(pass)
    );

    lfsr_selftest_seq #(.POLY(POLY), .SEED_A(SEED_A), .SEED_B(SEED_B)) u_seq (
        .clk(clk), .rst_n(rst_n), .ld(ld), .adv(adv),
        .seed_sel(seed_sel), .expect_val(expect_val)
    );

    lfsr_selftest_tally #(.DEPTH(DEPTH), .GOAL(GOAL)) u_tally (
        .clk(clk), .rst_n(rst_n), .clr(ld), .cmp_en(cmp_en),
        .word(rd_data), .expect_val(expect_val), .goal_met(goal_met)
    );
endmodule

// File: rtl/lfsr_selftest_chk.sv
module lfsr_selftest_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          done,
    input logic          pass
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_no_slot0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr != '0));

    p_addr_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

    p_idle_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_en);

    p_pass_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass) |-> (done || $past(start)));
endmodule

bind lfsr_selftest lfsr_selftest_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en),
    .rd_addr(rd_addr), .done(done), .pass(pass)
);

// File: tb/lfsr_selftest_tb.sv
module lfsr_selftest_tb;
    localparam int          DEPTH  = 8;
    localparam int          GOAL   = 3;
    localparam int          MAXP   = 16;
    localparam logic [63:0] POLY   = 64'h231DCEE91262B8A3;
    localparam logic [63:0] SEED_A = 64'hC3A55A3C0F1E2D4B;
    localparam logic [63:0] SEED_B = 64'h8000000000000001;
    localparam int          AW     = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          seed_sel = 1'b0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [63:0]   rd_data = '0;
    logic          done, pass;
    logic [63:0]   mem [DEPTH];
    int            reads = 0;
    int            zreads = 0;
    int            total = 0;
    int            bad = 0;

    always #10 clk = ~clk;

    lfsr_selftest #(.DEPTH(DEPTH), .GOAL(GOAL), .MAX_PASSES(MAXP),
                    .POLY(POLY), .SEED_A(SEED_A), .SEED_B(SEED_B)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed_sel(seed_sel),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .pass(pass)
    );

    // buffer model: synchronous read, one cycle latency
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
            reads++;
            if (rd_addr == '0) zreads++;
        end
    end

    // vector: {pattern[2:0], fill_sel, run_sel, exp_pass, exp_passes[4:0]}
    localparam int NV = 9;
    localparam logic [10:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b0, 1'b1, 5'd1},
        {3'd0, 1'b1, 1'b1, 1'b1, 5'd1},
        {3'd0, 1'b0, 1'b1, 1'b0, 5'd16},
        {3'd1, 1'b0, 1'b0, 1'b0, 5'd16},
        {3'd2, 1'b0, 1'b0, 1'b1, 5'd4},
        {3'd3, 1'b1, 1'b1, 1'b0, 5'd16},
        {3'd4, 1'b0, 1'b0, 1'b1, 5'd16},
        {3'd5, 1'b1, 1'b1, 1'b0, 5'd16},
        {3'd6, 1'b1, 1'b1, 1'b1, 5'd3}
    };

    function automatic logic [63:0] nxt(input logic [63:0] v);
        return v[63] ? ({v[62:0], 1'b0} ^ POLY) : {v[62:0], 1'b0};
    endfunction

    function automatic logic [63:0] st(input int k, input logic sel);
        logic [63:0] v = sel ? SEED_B : SEED_A;
        for (int i = 0; i < k; i++) v = nxt(v);
        return v;
    endfunction

    task automatic fill(input int pat, input logic sel);
        for (int i = 0; i < DEPTH; i++) mem[i] = 64'h0;
        case (pat)
            0: for (int i = 0; i < DEPTH; i++) mem[i] = st(0, sel);
            1: mem[0] = st(0, sel);
            2: for (int i = 1; i < DEPTH; i++) mem[i] = st(i, sel);
            3: begin mem[1] = st(0, sel); mem[2] = st(0, sel); end
            4: begin mem[1] = st(0, sel); mem[2] = st(0, sel); mem[3] = st(MAXP-1, sel); end
            5: begin mem[1] = st(0, sel); mem[2] = st(0, sel); mem[3] = st(MAXP, sel); end
            default: for (int i = 1; i < 4; i++) mem[i] = st(2, sel);
        endcase
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // launch one run; inj>0 raises start again at that cycle of the run
    task automatic run(input logic sel, input int inj, output int lat, output logic res);
        int n = 0;
        @(negedge clk);
        seed_sel = sel;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = -1;
        while (n < 1000) begin
            start = (inj != 0 && n == inj);
            @(negedge clk);
            n++;
            if (done) begin lat = n; break; end
        end
        start = 1'b0;
        res = pass;
        if (lat < 0) chk(1'b0, "R8 watchdog on done", n, 0);
        @(negedge clk);
        chk(!done, "R8 done one cycle", done, 0);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        logic res;
        int r0;
        fill(0, 1'b0);
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!done && !pass && !rd_en, "R1 reset outputs", {done, pass, rd_en}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!done && !pass && !rd_en, "R1 after reset", {done, pass, rd_en}, 0);

        for (int v = 0; v < NV; v++) begin
            fill(int'(VEC[v][10:8]), VEC[v][7]);
            r0 = reads;
            run(VEC[v][6], 0, lat, res);
            // R2 R4 R5 R6 R7: outcome
            chk(res == VEC[v][5], $sformatf("R4 R5 R6 R7 R2 pass flag v%0d", v), res, VEC[v][5]);
            chk(lat == (DEPTH + 1) * int'(VEC[v][4:0]), $sformatf("R8 latency v%0d", v),
                lat, (DEPTH + 1) * int'(VEC[v][4:0]));
            chk(reads - r0 == (DEPTH - 1) * int'(VEC[v][4:0]), $sformatf("R3 read count v%0d", v),
                reads - r0, (DEPTH - 1) * int'(VEC[v][4:0]));
        end
        chk(zreads == 0, "R3 slot 0 never read", zreads, 0);

        // R10: stray start mid-run
        fill(2, 1'b0);
        run(1'b0, 12, lat, res);
        chk(lat == 4 * (DEPTH + 1), "R10 latency with busy start", lat, 4 * (DEPTH + 1));
        chk(res == 1'b1, "R10 outcome with busy start", res, 1);
        repeat (5) @(negedge clk);
        chk(pass == 1'b1, "R9 pass held", pass, 1);
        chk(!rd_en, "R10 no new run after busy start", rd_en, 0);

        // R9: pass clears after next accepted start
        fill(1, 1'b0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(pass == 1'b0, "R9 pass cleared on start", pass, 0);
        while (!done) @(negedge clk);
        chk(pass == 1'b0, "R6 fail result", pass, 0);
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule